// File: doc/BRIEF.md
# Dual-Channel Silence Detector and Output Mute

This block watches a stereo pair of signed sample streams, one sample per strobe, and reports on each channel separately when that channel has been silent for a long run. Every channel has its own run counter. The counter counts strobes that carry an all-zero sample and is cleared by any nonzero sample. When the count reaches the selected threshold, the channel's active-low silence flag goes low. A one-bit period select picks between a short run length and a long one.

The block also owns the sample words passed on to the downstream pulse-width modulator. It drives those words to zero, which the modulator turns into a 50% duty cycle, while a software mute bit is set or while the active-low initialise input is held low. Otherwise it loads each strobed sample and holds it between strobes. The silence flags report run detection only. Mute and initialise change the data path and never touch the flags, although initialise also clears the run counters.

Each channel runs a three-state machine. `ZD_IDLE` means the run count is zero. `ZD_RUN` means the count is between one and the threshold. `ZD_HIT` means the count has reached the threshold, and the flag is low only in this state. The transitions are:

- Start: `ZD_IDLE` to `ZD_RUN` on the first zero sample.
- Reach: `ZD_RUN` to `ZD_HIT` when the count reaches the threshold.
- Break: any state to `ZD_IDLE` on a nonzero sample or on initialise.
- Lengthen: `ZD_HIT` to `ZD_RUN` when the threshold is raised above the held count.
- Shorten: `ZD_RUN` to `ZD_HIT` when the threshold is lowered to or below the held count.
- Direct: `ZD_IDLE` to `ZD_HIT` when a threshold of one is met by a single zero sample.

Top module: `zero_mute_ctrl`

## Requirements
- R1: After reset both silence flags are high, both output words are zero and both run counts are zero.
- R2: On a cycle with `smp_stb` high and `init_n` high, a channel whose sample is all zeros has its run count raised by one. The count saturates at the threshold, which is `SHORT_RUN` when `run_sel` is 0 and `LONG_RUN` when `run_sel` is 1. The flag is low from the cycle after the count reaches the threshold.
- R3: The two channels count and flag independently. A sample on one channel never changes the other channel's count or flag.
- R4: A nonzero sample on a strobe clears that channel's count, and the flag is high in the next cycle.
- R5: A change of `run_sel` compares the new threshold against the held count without clearing it. Lowering the threshold to or below the count drops the flag in the next cycle. Raising it above the count raises the flag, and only the remaining zeros up to the new threshold are then needed.
- R6: While `init_n` is low, both counts clear, both flags are high, and both output words are zero from the next cycle on.
- R7: While `mute_req` is high, both output words are zero from the next cycle on. Counting and flags continue unaffected.
- R8: With `mute_req` low and `init_n` high, each output word loads its channel's sample on a strobe and holds its value between strobes.
- R9: A cycle without a strobe leaves both counts unchanged, apart from the effect of `init_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle sample strobe at the sampling rate |
| smp_l | input | DATA_W | Left sample, two's complement |
| smp_r | input | DATA_W | Right sample, two's complement |
| run_sel | input | 1 | Silence run length: 0 short, 1 long |
| mute_req | input | 1 | Register mute request |
| init_n | input | 1 | Active-low initialise |
| flag_l_n | output | 1 | Left silence flag, low when silence detected |
| flag_r_n | output | 1 | Right silence flag, low when silence detected |
| out_l | output | DATA_W | Left word to the modulator |
| out_r | output | DATA_W | Right word to the modulator |

## Verification
The bench builds the block with `SHORT_RUN` = 5, `LONG_RUN` = 12 and `DATA_W` = 8. With these values every zero-run length from zero to past the long threshold can be swept under both selects. It can also switch the select at every reachable count, so both directions of the threshold change are covered at each count. A long mixed run of strobes, idle cycles, mutes and initialise pulses follows, and its expected flags and words come from per-channel run counts kept in the bench.

// File: rtl/zmute_pkg.sv
package zmute_pkg;

    // Per-channel silence run state
    typedef enum logic [1:0] {
        ZD_IDLE = 2'd0,   // run count is zero
        ZD_RUN  = 2'd1,   // 0 < count < threshold
        ZD_HIT  = 2'd2    // count >= threshold, flag low
    } zd_state_e;

    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/zd_channel.sv
module zd_channel
    import zmute_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SHORT_RUN = 2500,
    parameter int unsigned LONG_RUN  = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              init_n,
    input  logic              run_sel,
    input  logic [DATA_W-1:0] smp,
    output logic              flag_n
);

    localparam int unsigned MAX_RUN = (LONG_RUN > SHORT_RUN) ? LONG_RUN : SHORT_RUN;
    localparam int unsigned CW      = $clog2(MAX_RUN + 1);
    localparam logic [CW-1:0] THR_S = CW'(SHORT_RUN);
    localparam logic [CW-1:0] THR_L = CW'(LONG_RUN);

    zd_state_e       st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   thr;
    logic            is_zero;

    assign thr     = run_sel ? THR_L : THR_S;
    assign is_zero = (smp == '0);

    // Run counter: advance on zero strobes, saturate, clear on data or init
    always_comb begin
        cnt_d = cnt_q;
        if (!init_n) begin
            cnt_d = '0;
        end else if (smp_stb) begin
            if (!is_zero) begin
                cnt_d = '0;
            end else if (cnt_q < thr) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ZD_IDLE: begin
                if (cnt_d != '0) begin
                    st_d = (cnt_d >= thr) ? ZD_HIT : ZD_RUN;   // start / direct
                end
            end
            ZD_RUN: begin
                if (cnt_d == '0) begin
                    st_d = ZD_IDLE;                            // break
                end else if (cnt_d >= thr) begin
                    st_d = ZD_HIT;                             // reach / shorten
                end
            end
            ZD_HIT: begin
                if (cnt_d == '0) begin
                    st_d = ZD_IDLE;                            // break
                end else if (cnt_d < thr) begin
                    st_d = ZD_RUN;                             // lengthen
                end
            end
            default: st_d = ZD_IDLE;
        endcase
    end

    // State and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ZD_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output decode
    always_comb begin
        flag_n = (st_q != ZD_HIT);
    end

endmodule

// File: rtl/zd_outreg.sv
module zd_outreg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              force_zero,
    input  logic [DATA_W-1:0] smp_in,
    output logic [DATA_W-1:0] smp_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_out <= '0;
        end else if (force_zero) begin
            smp_out <= '0;
        end else if (smp_stb) begin
            smp_out <= smp_in;
        end
    end

endmodule

// File: rtl/zero_mute_ctrl.sv
module zero_mute_ctrl
    import zmute_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SHORT_RUN = 2500,
    parameter int unsigned LONG_RUN  = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_l,
    input  logic [DATA_W-1:0] smp_r,
    input  logic              run_sel,
    input  logic              mute_req,
    input  logic              init_n,
    output logic              flag_l_n,
    output logic              flag_r_n,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r
);

    logic [DATA_W-1:0] smp_a  [NUM_CH];
    logic [DATA_W-1:0] out_a  [NUM_CH];
    logic              flag_a [NUM_CH];
    logic              force_zero;

    assign smp_a[0]   = smp_l;
    assign smp_a[1]   = smp_r;
    assign force_zero = mute_req | ~init_n;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        zd_channel #(
            .DATA_W    (DATA_W),
            .SHORT_RUN (SHORT_RUN),
            .LONG_RUN  (LONG_RUN)
        ) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_stb (smp_stb),
            .init_n  (init_n),
            .run_sel (run_sel),
            .smp     (smp_a[ch]),
            .flag_n  (flag_a[ch])
        );

        zd_outreg #(
            .DATA_W (DATA_W)
        ) u_out (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_stb    (smp_stb),
            .force_zero (force_zero),
            .smp_in     (smp_a[ch]),
            .smp_out    (out_a[ch])
        );
    end

    assign flag_l_n = flag_a[0];
    assign flag_r_n = flag_a[1];
    assign out_l    = out_a[0];
    assign out_r    = out_a[1];

endmodule

// File: rtl/zero_mute_chk.sv
module zero_mute_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_stb,
    input logic [DATA_W-1:0] smp_l,
    input logic [DATA_W-1:0] smp_r,
    input logic              mute_req,
    input logic              init_n,
    input logic              flag_l_n,
    input logic              flag_r_n,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r
);

    AST_NZ_RELEASE_L: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && init_n && (smp_l != '0) |=> flag_l_n); // R4

    AST_NZ_RELEASE_R: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && init_n && (smp_r != '0) |=> flag_r_n); // R4

    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |=> flag_l_n && flag_r_n && (out_l == '0) && (out_r == '0)); // R6

    AST_REG_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req |=> (out_l == '0) && (out_r == '0)); // R7

    AST_PASS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && init_n && !mute_req |=> (out_l == $past(smp_l)) && (out_r == $past(smp_r))); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb && init_n && !mute_req |=> $stable(out_l) && $stable(out_r)); // R8

endmodule

bind zero_mute_ctrl zero_mute_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .smp_l    (smp_l),
    .smp_r    (smp_r),
    .mute_req (mute_req),
    .init_n   (init_n),
    .flag_l_n (flag_l_n),
    .flag_r_n (flag_r_n),
    .out_l    (out_l),
    .out_r    (out_r)
);

// File: tb/tb_zero_mute_ctrl.sv
`timescale 1ns/1ps
module tb_zero_mute_ctrl;

    localparam int DW = 8;
    localparam int SH = 5;
    localparam int LG = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_stb = 1'b0;
    logic [DW-1:0] smp_l = '0;
    logic [DW-1:0] smp_r = '0;
    logic          run_sel = 1'b0;
    logic          mute_req = 1'b0;
    logic          init_n = 1'b1;
    logic          flag_l_n, flag_r_n;
    logic [DW-1:0] out_l, out_r;

    int vec_cnt  = 0;
    int fail_cnt = 0;
    bit done     = 1'b0;

    // bench model
    int            cnt_l = 0, cnt_r = 0;
    logic [DW-1:0] exp_ol = '0, exp_or = '0;

    always #2 clk = ~clk;

    zero_mute_ctrl #(.DATA_W(DW), .SHORT_RUN(SH), .LONG_RUN(LG)) dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
        .run_sel(run_sel), .mute_req(mute_req), .init_n(init_n),
        .flag_l_n(flag_l_n), .flag_r_n(flag_r_n), .out_l(out_l), .out_r(out_r)
    );

    function automatic int thr_of(input logic sel);
        return sel ? LG : SH;
    endfunction

    function automatic int next_cnt(input int c, input logic stb, input logic [DW-1:0] s,
                                    input logic sel, input logic ini);
        if (!ini) return 0;
        if (!stb) return c;
        if (s != '0) return 0;
        if (c < thr_of(sel)) return c + 1;
        return c;
    endfunction

    task automatic compare(input string tag);
        logic el, er;
        el = !(cnt_l >= thr_of(run_sel));
        er = !(cnt_r >= thr_of(run_sel));
        vec_cnt++;
        if (flag_l_n !== el) begin
            fail_cnt++;
            $display("FAIL %s flag_l_n got %b exp %b", tag, flag_l_n, el);
        end
        if (flag_r_n !== er) begin
            fail_cnt++;
            $display("FAIL %s flag_r_n got %b exp %b", tag, flag_r_n, er);
        end
        if (out_l !== exp_ol) begin
            fail_cnt++;
            $display("FAIL %s out_l got %0h exp %0h", tag, out_l, exp_ol);
        end
        if (out_r !== exp_or) begin
            fail_cnt++;
            $display("FAIL %s out_r got %0h exp %0h", tag, out_r, exp_or);
        end
    endtask

    // Called at a negedge: drive, clock once, update model, check at next negedge
    task automatic step(input string tag, input logic stb, input logic [DW-1:0] l,
                        input logic [DW-1:0] r, input logic sel, input logic mute,
                        input logic ini);
        smp_stb = stb; smp_l = l; smp_r = r; run_sel = sel; mute_req = mute; init_n = ini;
        @(posedge clk);
        cnt_l = next_cnt(cnt_l, stb, l, sel, ini);
        cnt_r = next_cnt(cnt_r, stb, r, sel, ini);
        if (mute || !ini) begin
            exp_ol = '0; exp_or = '0;
        end else if (stb) begin
            exp_ol = l; exp_or = r;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R2/R4/R9: every run length under both selects, idle cycle after each strobe
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n <= LG + 2; n++) begin
                for (int k = 0; k < n; k++) begin
                    step("R2 zero run", 1'b1, '0, '0, s[0], 1'b0, 1'b1);
                    step("R9 idle", 1'b0, 8'h55, 8'h66, s[0], 1'b0, 1'b1);
                end
                step("R4 nonzero release", 1'b1, 8'(n + 1), 8'h80, s[0], 1'b0, 1'b1);
            end
        end

        // R3: one channel silent, the other busy, then swapped
        for (int k = 0; k < LG + 3; k++)
            step("R3 left silent", 1'b1, '0, 8'(k + 1), 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < LG + 3; k++)
            step("R3 right silent", 1'b1, 8'(k | 1), '0, 1'b0, 1'b0, 1'b1);
        step("R3 clear", 1'b1, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1);

        // R5: switch the threshold at every reachable count
        for (int n = 0; n <= LG; n++) begin
            step("R5 clear", 1'b1, 8'h11, 8'h22, 1'b1, 1'b0, 1'b1);
            for (int k = 0; k < n; k++)
                step("R5 build", 1'b1, '0, '0, 1'b1, 1'b0, 1'b1);
            step("R5 shorten", 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
            step("R5 hold short", 1'b1, '0, '0, 1'b0, 1'b0, 1'b1);
            step("R5 lengthen", 1'b0, '0, '0, 1'b1, 1'b0, 1'b1);
            for (int k = 0; k < LG - SH + 1; k++)
                step("R5 remaining", 1'b1, '0, '0, 1'b1, 1'b0, 1'b1);
        end

        // R6: init during a silent run and with data present
        for (int k = 0; k < SH + 1; k++)
            step("R6 build", 1'b1, '0, '0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++)
            step("R6 init low", k[0], 8'(k + 3), '0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < SH + 1; k++)
            step("R6 after init", 1'b1, '0, 8'h7f, 1'b0, 1'b0, 1'b1);

        // R7: mute with data and silence; counting continues
        for (int k = 0; k < LG + 2; k++)
            step("R7 mute", 1'b1, (k < 3) ? 8'hA5 : 8'h00, 8'(k + 9), 1'b1, 1'b1, 1'b1);
        step("R7 unmute", 1'b1, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b1);

        // R8 and mixed: long pseudo-random sequence
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] rv;
            logic [DW-1:0] l, r;
            rv = $urandom;
            l = (rv[3:0] < 4'd13) ? '0 : DW'(rv[15:8]);
            r = (rv[7:4] < 4'd13) ? '0 : DW'(rv[23:16]);
            step("R8 mixed", rv[24] | rv[25], l, r, (k % 600) < 300,
                 rv[31:27] == 5'd0, rv[31:26] != 6'd1);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            fail_cnt++;
            $display("FAIL watchdog expired got running exp finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
            $finish;
        end
    end

endmodule